// File: doc/BRIEF.md
# EEPROM Word Auto-Read Engine

This block fetches one 16-bit word from a serial EEPROM that sits on an SPI bus. Software writes one 32-bit read register with a start bit and a word address. The engine then selects the EEPROM and sends a read command followed by a byte address. It clocks in two data bytes and assembles them into a word. It raises a done flag, and the word appears in the upper half of the same register. Software polls the done flag and picks up the word in a single read.

The SPI pins are shared with a path that lets the host drive the EEPROM directly. While that direct access is granted, the engine keeps its chip select high and its clock low. A start that arrives during the grant is parked and runs once the grant is released. A `busy` output is high from the cycle after a start is accepted until the cycle in which done rises.

The state machine has five states:
- `ST_IDLE`: waits for a start.
- `ST_DEFER`: a start is parked while the grant is high.
- `ST_SHIFT`: chip select is low and the 40-bit frame is clocked.
- `ST_TRAIL`: chip select is held low for half an SCK period after the last falling edge.
- `ST_DONE`: one cycle in which the word is stored and done is set.

The transitions are:
- IDLE→DEFER: start accepted while the grant is high.
- IDLE→SHIFT: start accepted with no grant.
- DEFER→SHIFT: grant seen low.
- SHIFT→TRAIL: falling edge after the 40th bit.
- TRAIL→DONE: hold time over.
- DONE→IDLE: unconditional.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `busy` is 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: `busy` is 1 from the cycle after a start is accepted until the cycle in which the done flag (bit 1) rises. It falls in that same cycle.
- R3: Each read is one chip-select-low frame of exactly 40 SCK rising edges. The frame carries opcode 0x03, then a 16-bit byte address equal to twice the word address, both MSB first. Then 16 data bits are read.
- R4: When a read completes, bit 1 of `reg_rdata` is 1 and bits 31:16 hold the word. Both stay unchanged until the next accepted start.
- R5: Word address N covers bytes 2N and 2N+1. The first byte received (byte 2N) lands in bits 23:16 and the second byte (byte 2N+1) in bits 31:24, each received MSB first.
- R6: A write with bit 0 set while idle is accepted. The done bit reads 0 in the next cycle, and the word address from bits ADDR_W+1:2 reads back in the same field.
- R7: While `host_grant` is 1, the engine never drops `spi_cs_n`. An accepted start stays parked with `busy` at 1 and runs once `host_grant` is sampled low. Chip select falls one cycle after that sample.
- R8: While selected, `spi_sck` has a period of CLK_DIV clocks. MOSI changes on falling edges, MISO is sampled on rising edges, and SCK is low whenever `spi_cs_n` is 1.
- R9: A write with bit 0 clear, or a start written while `busy` is 1, has no effect: the register contents, the transaction in flight and the SPI pins are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the read register |
| reg_wdata | input | 32 | Write data: bit 0 start, bits ADDR_W+1:2 word address |
| reg_rdata | output | 32 | Read register: bit 1 done, address field, bits 31:16 word |
| host_grant | input | 1 | Direct host access to the SPI pins is granted |
| busy | output | 1 | A read is parked or in progress |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_sck | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
Two events can coincide: a start write, and the release of the direct-access grant in the cycle that decides where the start goes. The bench raises the grant in the same cycle as the start write and drops it in the following cycle. It then checks that chip select is still high one sample after the write and low one sample later, which is exactly one cycle of deferral. A second case holds the grant for many cycles and confirms that no frame begins and that the parked read later returns the correct word.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_SHIFT,
        ST_TRAIL,
        ST_DONE
    } eewr_state_e;

    localparam logic [7:0] READ_OPCODE = 8'h03;
    localparam int         OPC_BITS    = 8;
    localparam int         BADDR_BITS  = 16;
    localparam int         WORD_BITS   = 16;
    localparam int         FRAME_BITS  = OPC_BITS + BADDR_BITS + WORD_BITS;

endpackage

// File: rtl/eewr_sck_gen.sv
module eewr_sck_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HCW-1:0] phase_q;
    logic           wrap;

    assign wrap      = run && (phase_q == HCW'(HALF - 1));
    assign rise_tick = wrap && !sck;
    assign fall_tick = wrap && sck;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            sck     <= 1'b0;
        end else if (!run) begin
            phase_q <= '0;
            sck     <= 1'b0;
        end else if (wrap) begin
            phase_q <= '0;
            sck     <= ~sck;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/eewr_shifter.sv
module eewr_shifter #(
    parameter int FRAME_BITS = 40,
    parameter int RX_BITS    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_val,
    input  logic                  shift,
    input  logic                  sample,
    input  logic                  miso,
    output logic                  mosi,
    output logic [RX_BITS-1:0]    rx
);
    logic [FRAME_BITS-1:0] tx_q;

    assign mosi = tx_q[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (shift) begin
            tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx <= '0;
        end else if (sample) begin
            rx <= {rx[RX_BITS-2:0], miso};
        end
    end
endmodule

// File: rtl/eewr_regs.sv
module eewr_regs #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              idle,
    input  logic              result_we,
    input  logic [15:0]       result,
    output logic              start_acc,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [31:0]       reg_rdata
);
    logic              done_q;
    logic [15:0]       word_q;
    logic [ADDR_W-1:0] addr_q;

    assign start_acc   = reg_wr && reg_wdata[0] && idle;
    assign launch_addr = start_acc ? reg_wdata[ADDR_W+1:2] : addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            word_q <= '0;
            addr_q <= '0;
        end else if (start_acc) begin
            done_q <= 1'b0;
            addr_q <= reg_wdata[ADDR_W+1:2];
        end else if (result_we) begin
            done_q <= 1'b1;
            word_q <= result;
        end
    end

    always_comb begin
        reg_rdata               = '0;
        reg_rdata[1]            = done_q;
        reg_rdata[ADDR_W+1:2]   = addr_q;
        reg_rdata[31:16]        = word_q;
    end
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
    import eewr_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int ADDR_W  = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        host_grant,
    output logic        busy,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int HALF = CLK_DIV / 2;
    localparam int TCW  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BCW  = $clog2(FRAME_BITS);

    eewr_state_e state_q, state_d;

    logic              start_acc;
    logic [ADDR_W-1:0] launch_addr;
    logic              sck_run, rise_tick, fall_tick;
    logic              enter_shift, result_we, trail_done, last_bit;
    logic [BCW-1:0]    bit_cnt_q;
    logic [TCW-1:0]    trail_cnt_q;
    logic [WORD_BITS-1:0] rx_bits;
    logic [15:0]       word_le;
    logic [BADDR_BITS-1:0] byte_addr;
    logic [FRAME_BITS-1:0] frame;

    // byte address = 2 x word address, zero-extended
    assign byte_addr = BADDR_BITS'({launch_addr, 1'b0});
    assign frame     = {READ_OPCODE, byte_addr, {WORD_BITS{1'b0}}};
    // first received byte (even address) becomes the low byte
    assign word_le   = {rx_bits[7:0], rx_bits[15:8]};

    assign last_bit   = (bit_cnt_q == BCW'(FRAME_BITS - 1));
    assign trail_done = (trail_cnt_q == TCW'(HALF - 1));

    eewr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .idle       (state_q == ST_IDLE),
        .result_we  (result_we),
        .result     (word_le),
        .start_acc  (start_acc),
        .launch_addr(launch_addr),
        .reg_rdata  (reg_rdata)
    );

    eewr_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sck_run),
        .sck      (spi_sck),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    eewr_shifter #(.FRAME_BITS(FRAME_BITS), .RX_BITS(WORD_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (enter_shift),
        .load_val(frame),
        .shift   (fall_tick),
        .sample  (rise_tick),
        .miso    (spi_miso),
        .mosi    (spi_mosi),
        .rx      (rx_bits)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_acc) state_d = host_grant ? ST_DEFER : ST_SHIFT;
            end
            ST_DEFER: begin
                if (!host_grant) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (fall_tick && last_bit) state_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (trail_done) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        spi_cs_n    = 1'b1;
        sck_run     = 1'b0;
        busy        = 1'b1;
        result_we   = 1'b0;
        enter_shift = (state_q != ST_SHIFT) && (state_d == ST_SHIFT);
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_DEFER: ;
            ST_SHIFT: begin
                spi_cs_n = 1'b0;
                sck_run  = 1'b1;
            end
            ST_TRAIL: spi_cs_n = 1'b0;
            ST_DONE:  result_we = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // frame bit counter, advanced on each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)          bit_cnt_q <= '0;
        else if (enter_shift) bit_cnt_q <= '0;
        else if (fall_tick)  bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    // chip-select hold timer
    always_ff @(posedge clk) begin
        if (!rst_n)                 trail_cnt_q <= '0;
        else if (state_q != ST_TRAIL) trail_cnt_q <= '0;
        else if (!trail_done)       trail_cnt_q <= trail_cnt_q + 1'b1;
    end
endmodule

// File: rtl/eewr_checker.sv
module eewr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        host_grant,
    input logic        busy,
    input logic        spi_cs_n,
    input logic        spi_sck,
    input logic        spi_mosi,
    input logic        spi_miso
);
    a_r2_select_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> reg_rdata[1]);

    a_r4_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && !(reg_wr && reg_wdata[0])) |=> (reg_rdata[1] && $stable(reg_rdata[31:16])));

    a_r6_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[0] && !busy) |=> !reg_rdata[1]);

    a_r7_grant_blocks_select: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && host_grant) |=> spi_cs_n);

    a_r8_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
endmodule

bind eeprom_word_reader eewr_checker u_chk (.*);

// File: tb/eeprom_word_reader_tb.sv
module eeprom_word_reader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;
    localparam int ADDR_W     = 14;
    localparam int WDOG       = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_grant = 1'b0;
    logic        busy, spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    eeprom_word_reader #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_grant(host_grant), .busy(busy),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == WDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- EEPROM model ----------------
    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 37) + (a >> 8) + 8'h5A);
    endfunction

    function automatic logic [15:0] exp_word(input int n);
        return {mem_byte(2*n + 1), mem_byte(2*n)};
    endfunction

    int          rises = 0;
    int          frames = 0;
    int          last_rises = 0;
    int          period_bad = 0;
    int          last_rise_cyc = 0;
    logic [39:0] frame_sh = '0;
    logic [39:0] last_frame = '0;
    logic [15:0] model_addr = '0;

    always @(negedge spi_cs_n) begin
        rises    = 0;
        frame_sh = '0;
        spi_miso = 1'b0;
    end

    always @(posedge spi_cs_n) begin
        if (rst_n) begin
            frames     = frames + 1;
            last_rises = rises;
            last_frame = frame_sh;
        end
    end

    always @(posedge spi_sck) begin
        if (rises > 0 && (cyc - last_rise_cyc) != CLK_DIV) period_bad = period_bad + 1;
        last_rise_cyc = cyc;
        frame_sh = {frame_sh[38:0], spi_mosi};
        rises = rises + 1;
        if (rises == 24) model_addr = frame_sh[15:0];
    end

    always @(negedge spi_sck) begin
        if (rises >= 24 && rises < 40) begin
            int k;
            logic [7:0] b;
            k = rises - 24;
            b = (k < 8) ? mem_byte(int'(model_addr)) : mem_byte(int'(model_addr) + 1);
            spi_miso = b[7 - (k % 8)];
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_done(output bit ok, output bit busy_ok);
        ok = 1'b0;
        busy_ok = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (reg_rdata[1]) begin
                ok = 1'b1;
                if (busy) busy_ok = 1'b0;
                break;
            end
            if (!busy) busy_ok = 1'b0;
        end
    endtask

    task automatic check_result(input int n, input int frames_before);
        logic [15:0] w;
        w = exp_word(n);
        chk(frames == frames_before + 1, "R3 one frame", 32'(frames), 32'(frames_before + 1));
        chk(last_rises == 40, "R3 sck rises per frame", 32'(last_rises), 32'd40);
        chk(last_frame[39:32] == 8'h03, "R3 opcode", 32'(last_frame[39:32]), 32'h03);
        chk(last_frame[31:16] == 16'(2*n), "R3 byte address", 32'(last_frame[31:16]), 32'(2*n));
        chk(reg_rdata[31:16] == w, "R4 R5 word", 32'(reg_rdata[31:16]), 32'(w));
        chk(reg_rdata[23:16] == mem_byte(2*n), "R5 low byte is even byte", 32'(reg_rdata[23:16]), 32'(mem_byte(2*n)));
        chk(reg_rdata[ADDR_W+1:2] == ADDR_W'(n), "R6 address readback", 32'(reg_rdata[ADDR_W+1:2]), 32'(n));
        chk(period_bad == 0, "R8 sck period", 32'(period_bad), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
        chk(!busy, "R1 busy", 32'(busy), 32'h0);
        chk(spi_cs_n, "R1 cs_n", 32'(spi_cs_n), 32'h1);
        chk(!spi_sck, "R1 sck", 32'(spi_sck), 32'h0);
    endtask

    task automatic t_plain_read(input int n);
        int f0;
        bit ok, bok;
        f0 = frames;
        reg_write(32'((n << 2) | 1));
        chk(busy, "R2 busy after start", 32'(busy), 32'h1);
        chk(!reg_rdata[1], "R6 done cleared", 32'(reg_rdata[1]), 32'h0);
        wait_done(ok, bok);
        chk(ok, "R4 done set", 32'(ok), 32'h1);
        chk(bok, "R2 busy until done", 32'(bok), 32'h1);
        repeat (3) @(negedge clk);
        check_result(n, f0);
        chk(reg_rdata[1], "R4 done held", 32'(reg_rdata[1]), 32'h1);
    endtask

    task automatic t_ignored;
        int f0;
        bit ok, bok;
        logic [31:0] snap;
        f0 = frames;
        reg_write(32'((20 << 2) | 1));
        repeat (30) @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'((33 << 2) | 1);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        wait_done(ok, bok);
        chk(ok, "R9 read completes", 32'(ok), 32'h1);
        repeat (100) @(negedge clk);
        check_result(20, f0);
        chk(spi_cs_n && !busy, "R9 no second frame", 32'(spi_cs_n), 32'h1);
        snap = reg_rdata;
        reg_write(32'(17 << 2));
        repeat (20) @(negedge clk);
        chk(reg_rdata == snap, "R9 bit0 clear ignored", reg_rdata, snap);
        chk(!busy && spi_cs_n && frames == f0 + 1, "R9 bit0 clear no frame", 32'(frames), 32'(f0 + 1));
    endtask

    task automatic t_defer;
        int f0;
        bit ok, bok, cs_stay;
        f0 = frames;
        @(negedge clk);
        host_grant = 1'b1;
        reg_write(32'((9 << 2) | 1));
        cs_stay = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!spi_cs_n || !busy || reg_rdata[1]) cs_stay = 1'b0;
        end
        chk(cs_stay, "R7 parked under grant", 32'(cs_stay), 32'h1);
        host_grant = 1'b0;
        wait_done(ok, bok);
        chk(ok, "R7 parked read completes", 32'(ok), 32'h1);
        repeat (3) @(negedge clk);
        check_result(9, f0);
    endtask

    task automatic t_same_cycle_release;
        int f0;
        bit ok, bok;
        f0 = frames;
        @(negedge clk);
        host_grant = 1'b1;
        reg_wr = 1'b1; reg_wdata = 32'((77 << 2) | 1);
        @(negedge clk);
        host_grant = 1'b0;
        reg_wr = 1'b0; reg_wdata = '0;
        chk(spi_cs_n && busy, "R7 deferred one cycle", 32'(spi_cs_n), 32'h1);
        @(negedge clk);
        chk(!spi_cs_n, "R7 select after release", 32'(spi_cs_n), 32'h0);
        wait_done(ok, bok);
        chk(ok, "R7 release read completes", 32'(ok), 32'h1);
        repeat (3) @(negedge clk);
        check_result(77, f0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_read(5);
        t_plain_read(0);
        t_plain_read((1 << ADDR_W) - 1);
        t_plain_read(300);
        t_ignored();
        t_defer();
        t_same_cycle_release();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule